// File: doc/BRIEF.md
# Large-Warp Sub-Warp Former

This block takes the active-thread mask of one large warp, whose thread count is a multiple of the SIMD width, and turns it into a series of dense sub-warps that fit the existing SIMD pipeline. It emits one sub-warp per clock. The mask is treated as a grid of `ROWS` rows by `LANES` columns, and each column maps to one SIMD lane. Every cycle, each column is searched on its own for its lowest remaining active row. The threads found this way form the next sub-warp and are then removed from the held mask. This lets threads from different rows share one issue slot instead of leaving lanes idle.

A new mask is accepted with a valid/ready handshake, and only when the previous one has been fully drained. A branch-type input chooses how the mask is drained. A conditional instruction is split into as many sub-warps as its busiest column needs, and the last-sub-warp flag tells the fetch stage it may refetch. An unconditional branch is finished in a single cycle.

Top module: `sw_former`

## Requirements
- R1: Input mask bit `r*LANES + c` is the thread in row `r`, column `c`. Lane `c` of every sub-warp carries only threads of column `c`.
- R2: For a conditional instruction, each lane takes the lowest-numbered row still active in its column. That row number is reported on `sw_row_sel[c*ROW_W +: ROW_W]`.
- R3: A lane whose column has no remaining active thread is inactive in `sw_lane_mask`, and its row field reads zero.
- R4: Threads issued in a sub-warp are removed from the held mask. A conditional mask therefore yields exactly as many sub-warps as its largest column population, on consecutive cycles, and every active thread is issued exactly once.
- R5: `sw_last` is high together with the final sub-warp of a conditional mask and in no earlier cycle.
- R6: When `in_uncond` is 1 at acceptance, exactly one cycle is presented. In that cycle the lane mask is the OR of each column, the row fields hold each column's lowest active row, and `sw_last` is high.
- R7: An all-zero mask produces no sub-warp. `sw_valid` stays low and `sw_last` is high for one cycle, the cycle after acceptance.
- R8: `in_ready` is high only while no mask is held, and a mask is taken on a clock edge where `in_valid` and `in_ready` are both high. The first result appears in the cycle after that edge, and `in_ready` returns in the cycle after the one with `sw_last`. Any input presented while a mask is held has no effect on the outputs.
- R9: After synchronous reset, `in_ready` is 1 and `sw_valid` and `sw_last` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Large-warp mask offered |
| in_ready | output | 1 | Former idle, mask may be taken |
| in_mask | input | ROWS*LANES | Active-thread mask, row-major |
| in_uncond | input | 1 | 1 = unconditional branch, 0 = conditional/other instruction |
| sw_valid | output | 1 | A sub-warp is presented this cycle |
| sw_lane_mask | output | LANES | Active lanes of the sub-warp |
| sw_row_sel | output | LANES*ROW_W | Source row per lane, lane c at bits c*ROW_W |
| sw_last | output | 1 | Final cycle of the current large warp; refetch may proceed |

## Verification
Once a mask is taken on a rising edge, the first sub-warp is due in the cycle that edge begins. Each later sub-warp follows one cycle after the previous one, and `in_ready` is due again one cycle after the `sw_last` cycle. The bench drives inputs and samples all outputs on falling edges, so each comparison sits in the middle of the cycle in which the model says the value is due. While a mask is draining, the bench keeps offering random masks and flips the branch type. It then checks that the remaining sub-warps still follow the model of the held mask.

// File: rtl/sw_pkg.sv
package sw_pkg;

    // Default geometry: 256-thread large warp on a 32-lane SIMD pipeline.
    localparam int unsigned DEF_LANES = 32;
    localparam int unsigned DEF_ROWS  = 8;

    // How a held mask is drained.
    typedef enum logic {
        BR_COND   = 1'b0,   // split into as many sub-warps as needed
        BR_UNCOND = 1'b1    // single-cycle completion
    } br_kind_e;

    // Width of a row index for a given row count (at least one bit).
    function automatic int unsigned row_bits(input int unsigned rows);
        return (rows > 1) ? $clog2(rows) : 1;
    endfunction

endpackage

// File: rtl/sw_col_pick.sv
// Fixed-priority search of one column: lowest active row wins.
module sw_col_pick #(
    parameter int unsigned ROWS  = 8,
    parameter int unsigned ROW_W = 3
) (
    input  logic [ROWS-1:0]  col_bits,
    output logic             hit,
    output logic [ROW_W-1:0] row_idx,
    output logic [ROWS-1:0]  grant
);

    always_comb begin
        hit     = |col_bits;
        row_idx = '0;
        grant   = '0;
        // Scan downward so the lowest set row is the last one written.
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (col_bits[r]) begin
                row_idx  = ROW_W'(r);
                grant    = '0;
                grant[r] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sw_mask_store.sv
// Holds the remaining mask of the large warp being drained.
module sw_mask_store
    import sw_pkg::*;
#(
    parameter int unsigned BITS = 256
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [BITS-1:0] load_mask,
    input  br_kind_e        load_kind,
    input  logic [BITS-1:0] clear_bits,
    input  logic            drain_done,
    output logic [BITS-1:0] rem_mask,
    output logic            busy,
    output br_kind_e        kind
);

    logic [BITS-1:0] rem_q;
    logic            busy_q;
    br_kind_e        kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            busy_q <= 1'b0;
            kind_q <= BR_COND;
        end else if (load) begin
            rem_q  <= load_mask;
            busy_q <= 1'b1;
            kind_q <= load_kind;
        end else if (busy_q) begin
            rem_q <= rem_q & ~clear_bits;
            if (drain_done) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign rem_mask = rem_q;
    assign busy     = busy_q;
    assign kind     = kind_q;

endmodule

// File: rtl/sw_former.sv
// Large-warp sub-warp former: one dense sub-warp per cycle.
module sw_former
    import sw_pkg::*;
#(
    parameter int unsigned LANES = DEF_LANES,
    parameter int unsigned ROWS  = DEF_ROWS,
    localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int unsigned BITS  = ROWS * LANES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [BITS-1:0]        in_mask,
    input  logic                   in_uncond,
    output logic                   sw_valid,
    output logic [LANES-1:0]       sw_lane_mask,
    output logic [LANES*ROW_W-1:0] sw_row_sel,
    output logic                   sw_last
);

    logic [BITS-1:0] rem_mask;
    logic [BITS-1:0] pick_bits;
    logic [BITS-1:0] clear_bits;
    logic [BITS-1:0] left_mask;
    logic            busy;
    br_kind_e        kind;
    logic            load;

    assign in_ready = ~busy;
    assign load     = in_valid & ~busy;

    sw_mask_store #(.BITS(BITS)) u_store (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .load_mask  (in_mask),
        .load_kind  (in_uncond ? BR_UNCOND : BR_COND),
        .clear_bits (clear_bits),
        .drain_done (sw_last),
        .rem_mask   (rem_mask),
        .busy       (busy),
        .kind       (kind)
    );

    // One priority search per column; grants are scattered back to mask order.
    for (genvar c = 0; c < LANES; c++) begin : g_col
        logic [ROWS-1:0]  col_bits;
        logic [ROWS-1:0]  grant;
        logic             hit;
        logic [ROW_W-1:0] row_idx;

        for (genvar r = 0; r < ROWS; r++) begin : g_row
            assign col_bits[r]             = rem_mask[r*LANES + c];
            assign pick_bits[r*LANES + c]  = grant[r];
        end

        sw_col_pick #(.ROWS(ROWS), .ROW_W(ROW_W)) u_pick (
            .col_bits (col_bits),
            .hit      (hit),
            .row_idx  (row_idx),
            .grant    (grant)
        );

        assign sw_lane_mask[c]                = busy & hit;
        assign sw_row_sel[c*ROW_W +: ROW_W]   = (busy & hit) ? row_idx : '0;
    end

    // An unconditional branch retires the whole mask at once.
    assign clear_bits = (kind == BR_UNCOND) ? rem_mask : pick_bits;
    assign left_mask  = rem_mask & ~clear_bits;
    assign sw_valid   = busy & (|rem_mask);
    assign sw_last    = busy & ~(|left_mask);

endmodule

// File: rtl/sw_former_checker.sv
// Temporal checks on the sub-warp former ports.
module sw_former_checker #(
    parameter int unsigned LANES = 32,
    parameter int unsigned ROWS  = 8,
    localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic                   sw_valid,
    input logic [LANES-1:0]       sw_lane_mask,
    input logic [LANES*ROW_W-1:0] sw_row_sel,
    input logic                   sw_last
);

    // R8: idle means nothing is presented
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (!sw_valid && !sw_last));

    // R8: an accepted mask makes the former busy on the next cycle
    a_r8_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R5: the last cycle hands the former back
    a_r5_last_frees: assert property (@(posedge clk) disable iff (rst)
        sw_last |=> in_ready);

    // R4: a non-final sub-warp is followed by another one
    a_r4_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (sw_valid && !sw_last) |=> (sw_valid && !in_ready));

    // R7: an empty completion carries no lanes
    a_r7_empty_no_lanes: assert property (@(posedge clk) disable iff (rst)
        (sw_last && !sw_valid) |-> (sw_lane_mask == '0));

    // R3: inactive lanes report row zero
    for (genvar c = 0; c < LANES; c++) begin : g_lane
        a_r3_idle_row_zero: assert property (@(posedge clk) disable iff (rst)
            !sw_lane_mask[c] |-> (sw_row_sel[c*ROW_W +: ROW_W] == '0));
    end

endmodule

bind sw_former sw_former_checker #(.LANES(LANES), .ROWS(ROWS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .sw_valid     (sw_valid),
    .sw_lane_mask (sw_lane_mask),
    .sw_row_sel   (sw_row_sel),
    .sw_last      (sw_last)
);

// File: tb/sw_former_tb_top.sv
`timescale 1ns/1ps
module sw_former_tb_top;

    localparam int unsigned LANES = 32;
    localparam int unsigned ROWS  = 8;
    localparam int unsigned ROW_W = 3;
    localparam int unsigned BITS  = ROWS * LANES;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   in_valid = 1'b0;
    logic                   in_ready;
    logic [BITS-1:0]        in_mask = '0;
    logic                   in_uncond = 1'b0;
    logic                   sw_valid;
    logic [LANES-1:0]       sw_lane_mask;
    logic [LANES*ROW_W-1:0] sw_row_sel;
    logic                   sw_last;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sw_former #(.LANES(LANES), .ROWS(ROWS)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_mask      (in_mask),
        .in_uncond    (in_uncond),
        .sw_valid     (sw_valid),
        .sw_lane_mask (sw_lane_mask),
        .sw_row_sel   (sw_row_sel),
        .sw_last      (sw_last)
    );

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One sub-warp step of the reference: per column, lowest active row.
    function automatic void model_step(
        input  logic [BITS-1:0]        rem,
        input  logic                   unc,
        output logic [LANES-1:0]       lm,
        output logic [LANES*ROW_W-1:0] rs,
        output logic [BITS-1:0]        nxt);
        lm  = '0;
        rs  = '0;
        nxt = rem;
        for (int c = 0; c < LANES; c++) begin
            for (int r = 0; r < ROWS; r++) begin
                if (rem[r*LANES + c] && !lm[c]) begin
                    lm[c] = 1'b1;
                    rs[c*ROW_W +: ROW_W] = ROW_W'(r);
                    nxt[r*LANES + c] = 1'b0;
                end
            end
        end
        if (unc) nxt = '0;
    endfunction

    function automatic logic [BITS-1:0] rnd_mask(input int dens);
        logic [BITS-1:0] m;
        for (int w = 0; w < BITS/32; w++) begin
            logic [31:0] v;
            v = $urandom();
            if (dens == 0) v = v & $urandom() & $urandom();
            else if (dens == 2) v = v | $urandom();
            m[w*32 +: 32] = v;
        end
        return m;
    endfunction

    // Offer one large warp and follow it to completion.
    task automatic run_warp(input logic [BITS-1:0] mask, input logic unc);
        logic [BITS-1:0]        rem;
        logic [LANES-1:0]       e_lm;
        logic [LANES*ROW_W-1:0] e_rs;
        logic [BITS-1:0]        e_nxt;
        logic                   e_last;
        int                     steps;
        rem = mask;
        @(negedge clk);
        check("R8 ready before accept", 256'(in_ready), 256'(1));
        in_valid  = 1'b1;
        in_mask   = mask;
        in_uncond = unc;
        @(negedge clk);
        // R8: junk offered while busy must not disturb the held mask
        in_mask   = rnd_mask(1);
        in_uncond = ~unc;
        steps = 0;
        while (!done) begin
            model_step(rem, unc, e_lm, e_rs, e_nxt);
            e_last = (e_nxt == '0);
            check("R8 busy not ready", 256'(in_ready), 256'(0));
            check(mask == '0 ? "R7 valid" : "R4 valid", 256'(sw_valid), 256'(rem != '0));
            check(unc ? "R6 lanes" : "R1 lanes", 256'(sw_lane_mask), 256'(e_lm));
            check(unc ? "R6 rows" : "R2 rows", 256'(sw_row_sel), 256'(e_rs));
            check(unc ? "R6 last" : (mask == '0 ? "R7 last" : "R5 last"), 256'(sw_last), 256'(e_last));
            steps++;
            if (e_last || steps > ROWS + 1) begin
                in_valid = 1'b0;
                break;
            end
            rem = e_nxt;
            @(negedge clk);
        end
        @(negedge clk);
        check("R8 ready after last", 256'(in_ready), 256'(1));
        check("R3 idle lanes", 256'(sw_lane_mask), 256'(0));
    endtask

    initial begin
        logic [BITS-1:0] m;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R9 in_ready", 256'(in_ready), 256'(1));
        check("R9 sw_valid", 256'(sw_valid), 256'(0));
        check("R9 sw_last",  256'(sw_last),  256'(0));

        run_warp('0, 1'b0);                        // R7 empty conditional
        run_warp('0, 1'b1);                        // R7 empty unconditional
        run_warp('1, 1'b0);                        // R4 full: eight full sub-warps
        m = '0;
        for (int r = 0; r < ROWS; r++) m[r*LANES + 5] = 1'b1;
        run_warp(m, 1'b0);                         // R3 one column only
        m = '0;
        m[BITS-1] = 1'b1;
        run_warp(m, 1'b0);                         // R2 single thread, top row
        m = '0;
        for (int r = 0; r < ROWS; r++) m[r*LANES + r] = 1'b1;
        run_warp(m, 1'b0);                         // R1 diagonal packs to one
        run_warp('1, 1'b1);                        // R6 full unconditional
        for (int i = 0; i < 60; i++) begin
            run_warp(rnd_mask(i % 3), ($urandom() % 4) == 0);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_fail++;
            $display("FAIL watchdog R8 actual=hung expected=drained");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule